// File: doc/BRIEF.md
# Program Flash Table Access Controller

This block connects an 8-bit data side to a 16-bit-wide program memory. It works through one byte-wide transfer latch and a byte-granular pointer. A table read fetches the word that holds the addressed byte and copies the high or low half into the latch. A table write copies the latch into one byte of a small bank of holding registers. The array itself changes only when software asks for a commit. There are two commits: one programs an entire holding block, the other erases a larger aligned row.

Each commit runs for a fixed number of clock cycles. This count stands in for the programming time. While a commit runs, the block holds a stall line toward the instruction fetch path, and the array is reserved for the commit. When the stall drops, a single-cycle done pulse marks the end. Programming can only clear bits, so each stored word is the old word ANDed with the holding data. An erase returns a row to all ones. The array sits outside the block, behind a word-wide port with asynchronous read and clocked write.

Top module: `flash_table_ctrl`

## Requirements
- R1: One cycle after a table read is accepted, the latch holds a byte of the word at pointer bits [PTR_W-1:1]. Pointer bit 0 picks the half: 0 gives bits [7:0], 1 gives bits [15:8]. Any byte address is legal.
- R2: When an accepted read or table write has postInc high, the pointer advances by one afterwards, and all ones wraps to zero. A pointer load in the same cycle wins over the increment. The access itself uses the old pointer.
- R3: A table write copies the latch into holding byte number ptr[2:0] and leaves the array untouched.
- R4: A program commit writes the 8-byte block selected by the pointer with bits [2:0] ignored. Every stored byte becomes old AND holding. At the end of the commit, all holding bytes return to 0xFF.
- R5: An erase commit sets all 64 bytes of the row selected by the pointer with bits [5:0] ignored to 0xFF. Words outside the row are untouched. Erase wins when both commit requests arrive together.
- R6: fetchStall rises the cycle after a commit is accepted. It stays high for exactly PROG_CYCLES cycles for a program and ERASE_CYCLES cycles for an erase. done is high only in the first cycle after fetchStall falls.
- R7: While fetchStall is high, commit requests and table writes have no effect, and the array is written only during a commit.
- R8: A read requested while fetchStall is high is held. It executes in the cycle done is high, using the pointer value and the postInc setting given with the request. Until then the latch keeps its value.
- R9: A read takes priority over a table write and over a latch load presented in the same idle cycle; those two are dropped.
- R10: Reset clears the pointer, latch, fetchStall and done, and fills the holding bytes with 0xFF. A program commit with no table writes therefore leaves the block unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ptrLoad | input | 1 | Load the byte pointer from ptrIn |
| ptrIn | input | PTR_W | New pointer value |
| postInc | input | 1 | Advance the pointer after this read or table write |
| rdReq | input | 1 | Table read request |
| wrReq | input | 1 | Table write request (latch to holding byte) |
| latchLoad | input | 1 | Load the latch from latchIn |
| latchIn | input | 8 | Data-side byte for the latch |
| progReq | input | 1 | Start a block program commit |
| eraseReq | input | 1 | Start a row erase commit |
| latchOut | output | 8 | Latch contents |
| ptrOut | output | PTR_W | Current byte pointer |
| fetchStall | output | 1 | Commit in progress; instruction fetch must wait |
| done | output | 1 | One-cycle pulse when a commit completes |
| memAddr | output | PTR_W-1 | Array word address |
| memRdata | input | 16 | Array read word for memAddr |
| memWe | output | 1 | Array word write enable |
| memWdata | output | 16 | Array write word |

## Verification
A wrong pointer or latch in this block is visible at ptrOut and latchOut on the very next cycle. The reference model is compared against them every clock. A wrong holding byte or a wrong commit base stays hidden until a commit finishes. It then shows up as a wrong word in the array, which the bench checks block by block right after each done pulse. Errors in the commit counter or the pending-read logic change the stall length, the position of done, or the latch value in the done cycle. Each of these appears within one commit period.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2
  } ftc_op_e;

  // strobes from control to datapath, valid for the current cycle
  typedef struct packed {
    logic doRead;     // capture addressed byte into latch
    logic doHoldWr;   // latch -> holding byte
    logic doInc;      // post-increment pointer
    logic capBase;    // freeze commit base address
    logic wrArray;    // drive an array word write
    logic eraseSel;   // current commit is an erase
    logic rearmHold;  // refill holding bytes with ones
  } ftc_strobe_t;
endpackage

// File: rtl/ftc_ctrl.sv
module ftc_ctrl
  import ftc_pkg::*;
#(
  parameter int HOLD_BYTES   = 8,
  parameter int ERASE_BYTES  = 64,
  parameter int PROG_CYCLES  = 16,
  parameter int ERASE_CYCLES = 40
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 rdReq,
  input  logic                                 wrReq,
  input  logic                                 postInc,
  input  logic                                 progReq,
  input  logic                                 eraseReq,
  output ftc_strobe_t                          strobe,
  output logic [$clog2(ERASE_BYTES/2)-1:0]     wordIdx,
  output logic                                 stall,
  output logic                                 done
);
  localparam int HOLD_WORDS  = HOLD_BYTES / 2;
  localparam int ERASE_WORDS = ERASE_BYTES / 2;
  localparam int IDX_W       = $clog2(ERASE_WORDS);
  localparam int MAX_CYC     = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W       = $clog2(MAX_CYC + 1);

  ftc_op_e          opQ;
  logic [CNT_W-1:0] cnt;
  logic             rdPend;
  logic             pendInc;
  logic             doneQ;

  logic idle, readNow, incSel, lastCyc, writeCyc;

  always_comb begin
    idle     = (opQ == OP_IDLE);
    readNow  = idle && (rdReq || rdPend);
    incSel   = rdPend ? pendInc : postInc;
    lastCyc  = ((opQ == OP_PROG)  && (cnt == CNT_W'(PROG_CYCLES - 1))) ||
               ((opQ == OP_ERASE) && (cnt == CNT_W'(ERASE_CYCLES - 1)));
    writeCyc = ((opQ == OP_PROG)  && (cnt < CNT_W'(HOLD_WORDS))) ||
               ((opQ == OP_ERASE) && (cnt < CNT_W'(ERASE_WORDS)));

    strobe           = '0;
    strobe.doRead    = readNow;
    strobe.doHoldWr  = idle && wrReq && !readNow;
    strobe.doInc     = readNow ? incSel : (idle && wrReq && postInc);
    strobe.capBase   = idle && (progReq || eraseReq);
    strobe.wrArray   = writeCyc;
    strobe.eraseSel  = (opQ == OP_ERASE);
    strobe.rearmHold = (opQ == OP_PROG) && lastCyc;

    wordIdx = cnt[IDX_W-1:0];
    stall   = !idle;
    done    = doneQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ     <= OP_IDLE;
      cnt     <= '0;
      rdPend  <= 1'b0;
      pendInc <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (idle) begin
        cnt    <= '0;
        rdPend <= 1'b0;
        if (eraseReq)     opQ <= OP_ERASE;
        else if (progReq) opQ <= OP_PROG;
      end else begin
        if (rdReq) begin
          rdPend  <= 1'b1;
          pendInc <= postInc;
        end
        if (lastCyc) begin
          opQ   <= OP_IDLE;
          cnt   <= '0;
          doneQ <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ftc_datapath.sv
module ftc_datapath
  import ftc_pkg::*;
#(
  parameter int PTR_W       = 12,
  parameter int HOLD_BYTES  = 8,
  parameter int ERASE_BYTES = 64
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  ftc_strobe_t                          strobe,
  input  logic [$clog2(ERASE_BYTES/2)-1:0]     wordIdx,
  input  logic                                 ptrLoad,
  input  logic [PTR_W-1:0]                     ptrIn,
  input  logic                                 latchLoad,
  input  logic [7:0]                           latchIn,
  output logic [PTR_W-1:0]                     ptrOut,
  output logic [7:0]                           latchOut,
  output logic [PTR_W-2:0]                     memAddr,
  input  logic [WORD_W-1:0]                    memRdata,
  output logic                                 memWe,
  output logic [WORD_W-1:0]                    memWdata
);
  localparam int HOLD_LOG  = $clog2(HOLD_BYTES);
  localparam int ERASE_LOG = $clog2(ERASE_BYTES);
  localparam int HWI_W     = HOLD_LOG - 1;

  logic [PTR_W-1:0] ptrQ;
  logic [PTR_W-1:0] baseQ;
  logic [7:0]       latchQ;
  logic [7:0]       holdQ [HOLD_BYTES];

  logic [HWI_W-1:0]  holdWordSel;
  logic [WORD_W-1:0] holdWord;
  logic [7:0]        rdByte;

  always_comb begin
    holdWordSel = wordIdx[HWI_W-1:0];
    holdWord    = {holdQ[{holdWordSel, 1'b1}], holdQ[{holdWordSel, 1'b0}]};
    rdByte      = ptrQ[0] ? memRdata[15:8] : memRdata[7:0];

    if (strobe.wrArray) begin
      if (strobe.eraseSel) memAddr = {baseQ[PTR_W-1:ERASE_LOG], wordIdx};
      else                 memAddr = {baseQ[PTR_W-1:HOLD_LOG], holdWordSel};
    end else begin
      memAddr = ptrQ[PTR_W-1:1];
    end
    memWe    = strobe.wrArray;
    memWdata = strobe.eraseSel ? '1 : (memRdata & holdWord);
    ptrOut   = ptrQ;
    latchOut = latchQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ   <= '0;
      baseQ  <= '0;
      latchQ <= '0;
    end else begin
      if (ptrLoad)           ptrQ <= ptrIn;
      else if (strobe.doInc) ptrQ <= ptrQ + 1'b1;
      if (strobe.capBase)    baseQ <= ptrQ;
      if (strobe.doRead)     latchQ <= rdByte;
      else if (latchLoad)    latchQ <= latchIn;
    end
  end

  for (genvar g = 0; g < HOLD_BYTES; g++) begin : g_hold
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 holdQ[g] <= 8'hFF;
      else if (strobe.rearmHold) holdQ[g] <= 8'hFF;
      else if (strobe.doHoldWr && (ptrQ[HOLD_LOG-1:0] == HOLD_LOG'(g)))
        holdQ[g] <= latchQ;
    end
  end
endmodule

// File: rtl/flash_table_ctrl.sv
module flash_table_ctrl
  import ftc_pkg::*;
#(
  parameter int PTR_W        = 12,
  parameter int HOLD_BYTES   = 8,
  parameter int ERASE_BYTES  = 64,
  parameter int PROG_CYCLES  = 16,
  parameter int ERASE_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ptrLoad,
  input  logic [PTR_W-1:0]  ptrIn,
  input  logic              postInc,
  input  logic              rdReq,
  input  logic              wrReq,
  input  logic              latchLoad,
  input  logic [7:0]        latchIn,
  input  logic              progReq,
  input  logic              eraseReq,
  output logic [7:0]        latchOut,
  output logic [PTR_W-1:0]  ptrOut,
  output logic              fetchStall,
  output logic              done,
  output logic [PTR_W-2:0]  memAddr,
  input  logic [15:0]       memRdata,
  output logic              memWe,
  output logic [15:0]       memWdata
);
  localparam int IDX_W = $clog2(ERASE_BYTES / 2);

  ftc_strobe_t      strobe;
  logic [IDX_W-1:0] wordIdx;

  ftc_ctrl #(
    .HOLD_BYTES(HOLD_BYTES), .ERASE_BYTES(ERASE_BYTES),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .wrReq(wrReq), .postInc(postInc),
    .progReq(progReq), .eraseReq(eraseReq), .strobe(strobe), .wordIdx(wordIdx),
    .stall(fetchStall), .done(done)
  );

  ftc_datapath #(
    .PTR_W(PTR_W), .HOLD_BYTES(HOLD_BYTES), .ERASE_BYTES(ERASE_BYTES)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordIdx(wordIdx),
    .ptrLoad(ptrLoad), .ptrIn(ptrIn), .latchLoad(latchLoad), .latchIn(latchIn),
    .ptrOut(ptrOut), .latchOut(latchOut), .memAddr(memAddr), .memRdata(memRdata),
    .memWe(memWe), .memWdata(memWdata)
  );
endmodule

// File: rtl/ftc_checker.sv
module ftc_checker #(
  parameter int PTR_W        = 12,
  parameter int PROG_CYCLES  = 16,
  parameter int ERASE_CYCLES = 40
) (
  input logic             clk,
  input logic             rstN,
  input logic             ptrLoad,
  input logic             latchLoad,
  input logic [PTR_W-1:0] ptrOut,
  input logic [7:0]       latchOut,
  input logic             fetchStall,
  input logic             done,
  input logic             memWe,
  input logic [15:0]      memRdata,
  input logic [15:0]      memWdata
);
  logic [15:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           runLen <= '0;
    else if (fetchStall) runLen <= runLen + 1'b1;
    else                 runLen <= '0;
  end

  p_done_on_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!fetchStall && $past(fetchStall)));

  p_release_gives_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fetchStall) |-> done);

  p_stall_length_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fetchStall) |-> (runLen == 16'(PROG_CYCLES) || runLen == 16'(ERASE_CYCLES)));

  p_write_only_stalled_r7: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> fetchStall);

  p_clear_only_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && memWdata != 16'hFFFF) |-> ((memWdata & ~memRdata) == 16'h0000));

  p_ptr_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    (fetchStall && !ptrLoad) |=> (ptrOut == $past(ptrOut)));

  p_latch_held_r8: assert property (@(posedge clk) disable iff (!rstN)
    (fetchStall && !latchLoad) |=> $stable(latchOut));
endmodule

bind flash_table_ctrl ftc_checker #(
  .PTR_W(PTR_W), .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
) i_ftc_checker (
  .clk(clk), .rstN(rstN), .ptrLoad(ptrLoad), .latchLoad(latchLoad),
  .ptrOut(ptrOut), .latchOut(latchOut), .fetchStall(fetchStall), .done(done),
  .memWe(memWe), .memRdata(memRdata), .memWdata(memWdata)
);

// File: tb/test_flash_table_ctrl.sv
`timescale 1ns/1ps
module test_flash_table_ctrl;
  localparam int PW    = 12;
  localparam int PC    = 16;
  localparam int EC    = 40;
  localparam int NWORD = 1 << (PW - 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          ptrLoad = 1'b0, postInc = 1'b0, rdReq = 1'b0, wrReq = 1'b0;
  logic          latchLoad = 1'b0, progReq = 1'b0, eraseReq = 1'b0;
  logic [PW-1:0] ptrIn = '0;
  logic [7:0]    latchIn = '0;
  logic [7:0]    latchOut;
  logic [PW-1:0] ptrOut;
  logic          fetchStall, done, memWe;
  logic [PW-2:0] memAddr;
  logic [15:0]   memRdata, memWdata;

  logic [15:0] mem    [NWORD];
  logic [15:0] refMem [NWORD];

  int    nChecks = 0;
  int    nFail = 0;
  string phase = "R10";

  always #10 clk = ~clk;

  flash_table_ctrl #(.PTR_W(PW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) i_flash_table_ctrl (
    .clk(clk), .rstN(rstN), .ptrLoad(ptrLoad), .ptrIn(ptrIn), .postInc(postInc),
    .rdReq(rdReq), .wrReq(wrReq), .latchLoad(latchLoad), .latchIn(latchIn),
    .progReq(progReq), .eraseReq(eraseReq), .latchOut(latchOut), .ptrOut(ptrOut),
    .fetchStall(fetchStall), .done(done), .memAddr(memAddr), .memRdata(memRdata),
    .memWe(memWe), .memWdata(memWdata)
  );

  // array wrapper: asynchronous read, clocked write
  assign memRdata = mem[memAddr];
  always @(posedge clk) if (memWe) mem[memAddr] <= memWdata;

  initial begin
    for (int i = 0; i < NWORD; i++) begin
      mem[i]    = 16'((i * 40503) ^ 16'h5A3C);
      refMem[i] = mem[i];
    end
  end

  // behavioural reference model
  logic [PW-1:0] mPtr = '0;
  logic [7:0]    mLatch = '0;
  logic [7:0]    mHold [8] = '{default: 8'hFF};
  int            mBusy = 0;
  bit            mProg = 0, mDone = 0, mPend = 0, mPendInc = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPtr = '0; mLatch = '0; mBusy = 0; mDone = 0; mPend = 0; mPendInc = 0;
      for (int i = 0; i < 8; i++) mHold[i] = 8'hFF;
    end else if (mBusy != 0) begin
      mDone = 0;
      if (rdReq) begin mPend = 1; mPendInc = postInc; end
      if (ptrLoad) mPtr = ptrIn;
      if (latchLoad) mLatch = latchIn;
      mBusy = mBusy - 1;
      if (mBusy == 0) begin
        mDone = 1;
        if (mProg) for (int i = 0; i < 8; i++) mHold[i] = 8'hFF;
      end
    end else begin
      bit rd, inc;
      logic [15:0] w;
      int cur;
      mDone = 0;
      cur = int'(mPtr);
      rd  = rdReq || mPend;
      inc = 0;
      if (rd) begin
        w = refMem[cur / 2];
        mLatch = (cur % 2 == 1) ? w[15:8] : w[7:0];
        inc = mPend ? mPendInc : postInc;
        mPend = 0;
      end else begin
        if (wrReq) begin
          mHold[cur % 8] = mLatch;
          inc = postInc;
        end
        if (latchLoad) mLatch = latchIn;
      end
      if (eraseReq) begin
        for (int k = 0; k < 32; k++) refMem[(cur / 64) * 32 + k] = 16'hFFFF;
        mBusy = EC; mProg = 0;
      end else if (progReq) begin
        for (int k = 0; k < 4; k++)
          refMem[(cur / 8) * 4 + k] = refMem[(cur / 8) * 4 + k] & {mHold[2*k+1], mHold[2*k]};
        mBusy = PC; mProg = 1;
      end
      if (ptrLoad)  mPtr = ptrIn;
      else if (inc) mPtr = PW'(cur + 1);
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    chk("ptr R2", 32'(ptrOut), 32'(mPtr));
    chk("latch R1", 32'(latchOut), 32'(mLatch));
    chk("stall R6", 32'(fetchStall), 32'(mBusy != 0));
    chk("done R6", 32'(done), 32'(mDone));
  end

  task automatic chkMem(int lo, int n);
    for (int i = lo; i < lo + n; i++) chk($sformatf("mem[%0h]", i), 32'(mem[i]), 32'(refMem[i]));
  endtask

  task automatic setPtr(int v);
    ptrLoad = 1; ptrIn = PW'(v); @(negedge clk); ptrLoad = 0;
  endtask
  task automatic doRead(bit inc);
    rdReq = 1; postInc = inc; @(negedge clk); rdReq = 0; postInc = 0;
  endtask
  task automatic putLatch(int v);
    latchLoad = 1; latchIn = 8'(v); @(negedge clk); latchLoad = 0;
  endtask
  task automatic tblWrite(bit inc);
    wrReq = 1; postInc = inc; @(negedge clk); wrReq = 0; postInc = 0;
  endtask
  task automatic waitDone();
    for (int i = 0; i < 200 && !done; i++) @(negedge clk);
    @(negedge clk);
  endtask
  task automatic commit(bit er, bit pr);
    eraseReq = er; progReq = pr; @(negedge clk); eraseReq = 0; progReq = 0;
    waitDone();
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("reset ptr R10", 32'(ptrOut), 0);
    chk("reset latch R10", 32'(latchOut), 0);
    chk("reset stall R10", 32'(fetchStall), 0);
    rstN = 1;
    @(negedge clk);
    // R10: holding bytes are ones, so a bare program changes nothing
    setPtr(12'h300);
    commit(0, 1);
    chkMem(12'h180, 4);

    phase = "R1";
    setPtr(12'h123); doRead(0);
    setPtr(12'h124); doRead(0);
    doRead(0);

    phase = "R2";
    setPtr(12'h2FE); doRead(1); doRead(1); doRead(1);
    setPtr(12'hFFF); doRead(1);
    chk("wrap R2", 32'(ptrOut), 0);
    rdReq = 1; postInc = 1; ptrLoad = 1; ptrIn = 12'h050;
    @(negedge clk); rdReq = 0; postInc = 0; ptrLoad = 0;

    phase = "R9";
    rdReq = 1; latchLoad = 1; latchIn = 8'h3C;
    @(negedge clk); rdReq = 0; latchLoad = 0;
    setPtr(12'h061);
    rdReq = 1; wrReq = 1; postInc = 1;
    @(negedge clk); rdReq = 0; wrReq = 0; postInc = 0;

    phase = "R3";
    setPtr(12'h40A);
    for (int b = 0; b < 6; b++) begin
      putLatch(8'h11 * (b + 1) ^ 8'hF0);
      tblWrite(1);
    end
    chkMem(12'h204, 4);

    phase = "R4";
    setPtr(12'h409);
    commit(0, 1);
    chkMem(12'h203, 6);

    phase = "R7";
    setPtr(12'h408);
    progReq = 1; @(negedge clk); progReq = 0;
    repeat (3) @(negedge clk);
    putLatch(8'h00);
    wrReq = 1; progReq = 1; eraseReq = 1; @(negedge clk);
    wrReq = 0; progReq = 0; eraseReq = 0;
    phase = "R8";
    setPtr(12'h3A7);
    rdReq = 1; postInc = 1; @(negedge clk); rdReq = 0; postInc = 0;
    waitDone();
    chk("pending read R8", 32'(latchOut), 32'(refMem[12'h3A7 / 2][15:8]));
    phase = "R7";
    chkMem(12'h204, 4);
    commit(0, 1);
    chkMem(12'h204, 4);

    phase = "R5";
    setPtr(12'h7C5);
    commit(1, 1);
    chkMem(12'h3DF, 34);

    phase = "R4";
    setPtr(12'h7C0);
    for (int b = 0; b < 8; b++) begin
      putLatch(8'(b * 37 + 5));
      tblWrite(1);
    end
    setPtr(12'h7C7);
    commit(0, 1);
    chkMem(12'h3E0, 4);
    setPtr(12'h7C1); doRead(0);

    phase = "R6";
    setPtr(12'h100);
    commit(1, 0);
    chkMem(12'h080, 32);
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule